// File: doc/BRIEF.md
# Raw Entropy Bit Collector

This block gathers raw bits from an external entropy source and packs them into a small buffer of 32-bit words that software reads over a simple 32-bit register bus. Software programs a sampling divider and sets a generator-enable bit, then writes the number of bits it wants into a request register. The block samples the one-bit entropy input at the divided rate and stores each bit into the buffer, filling each word from its least significant bit upward.

While a collection runs, the request register reads back the number of bits still to be gathered, so software polls it until it reads zero and then reads the buffer. Only the raw path exists: the post-processing and health-test locations are present in the map but hold nothing. Reads are registered: the read data for an address appears one clock after the address is presented.

Top module: `trng_collector`

## Requirements
- R1: After reset the control register, the divider register and the request register all read zero, and no bits are collected.
- R2: The divider register at offset 0x00 keeps a 15-bit divide value D in bits [15:1]; bit 0 and bits [31:16] read zero. With D nonzero, the sample period is 2*D clocks: after a request write, bit m is taken on the (m+1)*2*D-th clock edge, so an N-bit request reads zero from the N*2*D-th edge on.
- R3: A divide value of zero behaves as one, giving a sample period of two clocks.
- R4: Bit 31 of the control register at offset 0x20 enables sampling and reads back; other bits read zero. While it is clear no bit is taken and the remaining count holds; setting it again resumes the collection.
- R5: Writing N to the request register at offset 0x50 starts a collection of N bits; a read returns the number of bits still outstanding, which is nonzero while collecting and exactly zero once all N bits are stored in the buffer.
- R6: A request above 256 is clamped to 256 and reads back as 256; a request of zero leaves the block idle with the register reading zero.
- R7: Bits are packed least significant bit first: bit m of a collection lands in bit (m mod 32) of buffer word m/32, and buffer word k is read at offset 0x80 + 4*k for k = 0..7.
- R8: When a collection ends inside a word, that word's unfilled upper bits read zero; buffer words beyond the last one touched keep their previous contents.
- R9: Writing the request register during a collection restarts it at bit 0 of word 0 with the new count; bits already gathered but not yet written as a full word are discarded.
- R10: The post-processing location 0x30, the health-test locations 0x40, 0x44 and 0x48, and every unmapped offset read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the address presented one clock earlier |
| ent_bit | input | 1 | Raw entropy bit from the noise source |

## Verification
The bench measures the exact clock at which the request register first reads zero for divide values of zero and three, which exposes a strobe period that is off by one, a zero divider that stalls or runs at full rate, and a first sample taken too early. It checks a request of 300 reading back 256 and a zero request staying idle, so a missing clamp or a wrapped count shows up at once. A scoreboard model of the buffer catches a reversed bit order, a partial final word left with stale upper bits, a restart that keeps stale partial bits or writes past its own length, and collection that continues while the enable bit is clear.

// File: rtl/trng_pkg.sv
package trng_pkg;
  localparam int unsigned OFS_DIV    = 8'h00;
  localparam int unsigned OFS_CTRL   = 8'h20;
  localparam int unsigned OFS_POST   = 8'h30;
  localparam int unsigned OFS_REQ    = 8'h50;
  localparam int unsigned OFS_BUF    = 8'h80;
  localparam int unsigned EN_BIT     = 31;
endpackage

// File: rtl/trng_strobe_gen.sv
module trng_strobe_gen #(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             strobe
);
  localparam int CW = DIV_W + 1;

  logic [DIV_W-1:0] div_eff;
  logic [CW-1:0]    last;
  logic [CW-1:0]    cnt;

  always_comb begin
    div_eff = (div == '0) ? DIV_W'(1) : div;
    last    = {div_eff, 1'b0} - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || !en || restart) cnt <= '0;
    else if (cnt == last)      cnt <= '0;
    else                       cnt <= cnt + CW'(1);
  end

  assign strobe = en && (cnt == last);

  // R2: the sample period is never shorter than two clocks
  a_r2_strobe_spacing: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);
endmodule

// File: rtl/trng_bit_packer.sv
module trng_bit_packer #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 32,
  localparam int MAX_BITS = WORDS * WORD_W,
  localparam int CNT_W    = $clog2(MAX_BITS + 1),
  localparam int IDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int POS_W    = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  start_n,
  input  logic              strobe,
  input  logic              ent,
  output logic [CNT_W-1:0]  remaining,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [WORD_W-1:0] wr_data
);
  logic [WORD_W-1:0] acc;
  logic [POS_W-1:0]  bit_pos;
  logic [IDX_W-1:0]  word_idx;
  logic              take;

  always_comb begin
    take    = strobe && (remaining != '0) && !start;
    wr_data = acc | (WORD_W'(ent) << bit_pos);
    wr_en   = take && ((bit_pos == POS_W'(WORD_W - 1)) || (remaining == CNT_W'(1)));
    wr_idx  = word_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
      acc       <= '0;
      bit_pos   <= '0;
      word_idx  <= '0;
    end else if (start) begin
      remaining <= start_n;
      acc       <= '0;
      bit_pos   <= '0;
      word_idx  <= '0;
    end else if (take) begin
      remaining <= remaining - CNT_W'(1);
      if (wr_en) begin
        acc      <= '0;
        bit_pos  <= '0;
        word_idx <= word_idx + IDX_W'(1);
      end else begin
        acc     <= wr_data;
        bit_pos <= bit_pos + POS_W'(1);
      end
    end
  end

  // R4: without a strobe or a new request the count does not move
  a_r4_count_frozen: assert property (@(posedge clk) disable iff (rst)
    (!start && !strobe) |=> $stable(remaining));
  // R5: each sample taken lowers the outstanding count by exactly one
  a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
    (!start && strobe && remaining != '0) |=> (remaining == $past(remaining) - CNT_W'(1)));
  // R6: the count never exceeds the buffer capacity
  always_ff @(posedge clk) begin
    if (!rst) a_r6_bound: assert (remaining <= CNT_W'(MAX_BITS));
  end
endmodule

// File: rtl/trng_word_buf.sv
module trng_word_buf #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 32,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/trng_collector.sv
module trng_collector
  import trng_pkg::*;
#(
  parameter int WORDS  = 8,
  parameter int DIV_W  = 15,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ent_bit
);
  localparam int WORD_W   = 32;
  localparam int MAX_BITS = WORDS * WORD_W;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);
  localparam int IDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int BUF_END  = OFS_BUF + 4 * WORDS;

  logic              gen_en;
  logic [DIV_W-1:0]  div_q;
  logic              req_wr;
  logic [CNT_W-1:0]  req_n;
  logic              strobe;
  logic [CNT_W-1:0]  remaining;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [WORD_W-1:0] wr_data;
  logic              in_buf;
  logic [IDX_W-1:0]  rd_idx;
  logic [WORD_W-1:0] buf_q;
  logic [31:0]       csr_q;
  logic              sel_buf_q;

  always_comb begin
    req_wr = bus_we && (bus_addr == ADDR_W'(OFS_REQ));
    req_n  = (bus_wdata > 32'(MAX_BITS)) ? CNT_W'(MAX_BITS) : bus_wdata[CNT_W-1:0];
    in_buf = (32'(bus_addr) >= 32'(OFS_BUF)) && (32'(bus_addr) < 32'(BUF_END));
    rd_idx = bus_addr[IDX_W+1:2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_en <= 1'b0;
      div_q  <= '0;
    end else if (bus_we) begin
      if (bus_addr == ADDR_W'(OFS_CTRL)) gen_en <= bus_wdata[EN_BIT];
      if (bus_addr == ADDR_W'(OFS_DIV))  div_q  <= bus_wdata[DIV_W:1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_q     <= '0;
      sel_buf_q <= 1'b0;
    end else begin
      sel_buf_q <= in_buf;
      case (bus_addr)
        ADDR_W'(OFS_DIV):  csr_q <= 32'({div_q, 1'b0});
        ADDR_W'(OFS_CTRL): csr_q <= {gen_en, 31'b0};
        ADDR_W'(OFS_REQ):  csr_q <= 32'(remaining);
        default:           csr_q <= '0;
      endcase
    end
  end

  assign bus_rdata = sel_buf_q ? buf_q : csr_q;

  trng_strobe_gen #(.DIV_W(DIV_W)) u_strobe (
    .clk(clk), .rst(rst), .en(gen_en), .restart(req_wr), .div(div_q), .strobe(strobe)
  );

  trng_bit_packer #(.WORDS(WORDS), .WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst(rst), .start(req_wr), .start_n(req_n), .strobe(strobe),
    .ent(ent_bit), .remaining(remaining), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  trng_word_buf #(.WORDS(WORDS), .WORD_W(WORD_W)) u_buf (
    .clk(clk), .we(wr_en), .waddr(wr_idx), .wdata(wr_data), .raddr(rd_idx), .rdata(buf_q)
  );

  // R6: a zero request leaves nothing outstanding
  a_r6_zero_idle: assert property (@(posedge clk) disable iff (rst)
    (req_wr && bus_wdata == 32'd0) |=> (remaining == '0));
  // R1: reset clears the enable bit
  a_r1_reset_off: assert property (@(posedge clk)
    rst |=> !gen_en);
endmodule

// File: tb/sim_trng_collector.sv
module sim_trng_collector;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ent_bit = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [8];
  logic [39:0] sb_q [$];
  logic [255:0] pat_a, pat_b, pat_c, pat_d;

  always #10 clk = ~clk;

  trng_collector u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ent_bit(ent_bit)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
  endtask

  function automatic logic [255:0] make_pat(input logic [31:0] seed);
    logic [31:0] x;
    logic [255:0] p;
    x = seed;
    for (int i = 0; i < 8; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      p[i*32 +: 32] = x;
    end
    return p;
  endfunction

  // Driver: requests n_req bits, feeds pattern bits in their sample windows,
  // measures when the count reaches zero and pushes expected buffer words.
  task automatic run_collect(input string tag, input int n_req, input int eff_n,
                             input int per, input logic [255:0] pat);
    int zero_at;
    int first_val;
    wr(8'h50, 32'(n_req));
    zero_at = -1;
    first_val = -1;
    for (int j = 0; j <= eff_n * per + 4; j++) begin
      ent_bit = pat[(j / per) % 256];
      @(posedge clk); #1;
      if (j == 0) first_val = int'(bus_rdata);
      if (bus_rdata == 32'd0 && zero_at < 0) zero_at = j;
    end
    check({tag, " R5 first count"}, 32'(first_val), 32'(eff_n));
    check({tag, " R2/R5 cycles to zero"}, 32'(zero_at), 32'(eff_n * per));
    for (int k = 0; k < 8; k++) begin
      int lo;
      logic [31:0] w;
      lo = k * 32;
      if (lo < eff_n) begin
        w = pat[lo +: 32];
        if (eff_n - lo < 32) w = w & ((32'd1 << (eff_n - lo)) - 32'd1);
        model[k] = w;
      end
    end
    for (int k = 0; k < 8; k++) sb_q.push_back({8'(8'h80 + 4 * k), model[k]});
  endtask

  // Monitor: pops expected words and compares them with the bus reads.
  task automatic drain_scoreboard(input string tag);
    logic [39:0] e;
    logic [31:0] d;
    while (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      rd(e[39:32], d);
      check({tag, " R7/R8 buffer word"}, d, e[31:0]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, c1, c2;
    int n;
    pat_a = make_pat(32'h1234_5678);
    pat_b = make_pat(32'hCAFE_0001);
    pat_c = make_pat(32'h0BAD_F00D);
    pat_d = make_pat(32'h7777_1111);
    repeat (3) @(posedge clk); #1;
    rst = 1'b0;

    rd(8'h20, d); check("R1 ctrl after reset", d, 32'h0);
    rd(8'h00, d); check("R1 divider after reset", d, 32'h0);
    rd(8'h50, d); check("R1 request after reset", d, 32'h0);

    // R2 field layout
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); check("R2 divider field", d, 32'h0000_FFFE);
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, d); check("R4 ctrl readback", d, 32'h8000_0000);

    // R10 inert locations
    wr(8'h30, 32'hFFFF_FFFF); rd(8'h30, d); check("R10 post ctrl", d, 32'h0);
    wr(8'h40, 32'hFFFF_FFFF); rd(8'h40, d); check("R10 health 0x40", d, 32'h0);
    wr(8'h44, 32'hFFFF_FFFF); rd(8'h44, d); check("R10 health 0x44", d, 32'h0);
    wr(8'h48, 32'hFFFF_FFFF); rd(8'h48, d); check("R10 health 0x48", d, 32'h0);
    wr(8'h64, 32'hFFFF_FFFF); rd(8'h64, d); check("R10 unmapped", d, 32'h0);
    rd(8'h20, d); check("R10 ctrl unchanged", d, 32'h8000_0000);

    // R4: disabled means nothing is taken, then pause and resume
    wr(8'h00, 32'd4);  // D = 2, period 4
    wr(8'h20, 32'h0);
    wr(8'h50, 32'd8);
    repeat (40) @(posedge clk); #1;
    rd(8'h50, d); check("R4 no sampling while disabled", d, 32'd8);
    wr(8'h50, 32'd40);
    wr(8'h20, 32'h8000_0000);
    ent_bit = 1'b1;
    repeat (30) @(posedge clk); #1;
    wr(8'h20, 32'h0);
    rd(8'h50, c1);
    repeat (50) @(posedge clk); #1;
    rd(8'h50, c2);
    check("R4 count held while paused", c2, c1);
    check("R4 paused mid-collection", 32'((c1 > 0) && (c1 < 40)), 32'd1);
    wr(8'h20, 32'h8000_0000);
    n = 0;
    d = 32'd1;
    while (d != 0 && n < 400) begin rd(8'h50, d); n++; end
    check("R4 resumes to completion", d, 32'h0);

    // R6 zero request
    wr(8'h50, 32'd0); rd(8'h50, d); check("R6 zero request idle", d, 32'h0);

    // R3 + R6 clamp: divide zero, request 300 -> 256 at period 2
    wr(8'h00, 32'd0);
    run_collect("full", 300, 256, 2, pat_a);
    drain_scoreboard("full");

    // R2 + R8: divide 3 (period 6), 70 bits ends inside word 2
    wr(8'h00, 32'd6);
    run_collect("partial", 70, 70, 6, pat_d);
    drain_scoreboard("partial");

    // R9 restart: start 64 bits, gather 10, then restart with 40
    wr(8'h00, 32'd0);
    wr(8'h50, 32'd64);
    for (int j = 0; j < 20; j++) begin
      ent_bit = pat_b[j / 2];
      @(posedge clk); #1;
    end
    rd(8'h50, d); check("R9 in progress before restart", 32'(d != 0), 32'd1);
    run_collect("restart R9", 40, 40, 2, pat_c);
    drain_scoreboard("restart R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule